// File: doc/BRIEF.md
# Cascaded Nested Vectored Interrupt Controller

This block collects interrupt requests from up to fifteen peripherals and presents them to a processor as one interrupt line. When the processor acknowledges, the block returns an 8-bit vector that identifies the source being serviced. The vector is a 5-bit programmable base followed by a 3-bit line index.

The block contains two identical eight-line units. The secondary unit takes lines 8 to 15. Its combined request drives primary input 2, so the fifteen usable lines are 0, 1 and 3 to 15. A peripheral wired to the old line 2 is treated as line 9.

Each unit has a request register, a per-line mask and an in-service register, and it nests interrupts. A request interrupts the current handler only if its priority is strictly higher than every level already in service. Software ends a handler with a non-specific end-of-interrupt strobe on each unit involved. A source on the secondary unit needs a strobe on both units.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are low and every mask bit is set. Requests raise no interrupt until a configuration write clears their mask bits.
- R2: Among the enabled primary lines, the lowest-numbered one wins. Its vector is `{base_pri, line[2:0]}`.
- R3: Lines 8 to 15 return `{base_sec, line-8}`. As a group they take the priority slot of primary input 2, so they rank below lines 0 and 1 and above lines 3 to 7.
- R4: A request on `irq_i[2]` is serviced exactly as a request on line 9.
- R5: A line whose mask bit is 1 raises no interrupt while masked. Its request stays pending and is serviced once the bit is cleared. Mask bit 2 blocks the whole secondary unit.
- R6: An acknowledge while `int_o` is high sets the in-service bit of the winning line. Requests of equal or lower priority then leave `int_o` low.
- R7: A request of strictly higher priority than every in-service level raises `int_o` again, and its acknowledge nests on top of the handler already running.
- R8: An end-of-interrupt strobe clears only the highest-priority in-service bit of its unit.
- R9: A secondary source stays in service on the secondary unit until `eoi_sec_i` is pulsed. A strobe on `eoi_pri_i` alone leaves the secondary's in-service state unchanged.
- R10: An acknowledge while `int_o` is low returns the spurious vector `{base_pri, 3'b111}` and sets no in-service bit.
- R11: `vec_vld_o` is high in exactly the cycle after each acknowledge cycle, and `vec_o` holds the vector during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Level requests; bit 2 is the legacy line, redirected to line 9 |
| cfg_we_i | input | 1 | Loads the mask and both vector bases |
| cfg_mask_i | input | 16 | Mask, 1 = masked; bits 7:0 primary, bits 15:8 secondary |
| cfg_base_pri_i | input | 5 | Vector base for the primary unit |
| cfg_base_sec_i | input | 5 | Vector base for the secondary unit |
| ack_i | input | 1 | Single-cycle interrupt acknowledge |
| eoi_pri_i | input | 1 | Non-specific end-of-interrupt to the primary unit |
| eoi_sec_i | input | 1 | Non-specific end-of-interrupt to the secondary unit |
| int_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Interrupt vector |

## Verification
The bench first targets cascade ordering. A request from line 15 must beat line 3 and lose to line 1; a design that ranked the secondary by raw line number would return the vector for line 3. It then drives the legacy line 2 alone and expects the vector for line 9; without the redirect no interrupt would appear at all.

Nesting is exercised with line 5 in service. A lower line must wait, and a higher line must preempt. After that, one end-of-interrupt strobe must leave line 5 in service; a design that cleared the whole register would let line 6 through too early.

For a secondary source, the bench strobes the primary unit alone and expects the interrupt to stay low. A design that lost the secondary in-service bit would raise the next secondary request too soon. An acknowledge with nothing pending must return the spurious vector and leave line 7 free to fire afterwards.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int UNIT_LINES = 8;
  localparam int BASE_W     = 5;
  localparam int LINK_LINE  = 2;
  localparam int REDIR_IDX  = 1;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = i[IW-1:0];
    end
  end
  assign found_o = |bits_i;
endmodule

// File: rtl/irq_nest_unit.sv
module irq_nest_unit #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          int_o,
  output logic [IW-1:0] win_o,
  output logic [N-1:0]  isr_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  irr_q, irr_d;
  logic [N-1:0]  isr_q, isr_d;
  logic          isr_en;
  logic [N-1:0]  pend;
  logic          pend_found, serv_found;
  logic [IW-1:0] pend_idx, serv_idx;
  logic [N-1:0]  set_vec, clr_vec;

  assign pend = irr_q & ~mask_i;

  irq_first_set #(.N(N), .IW(IW)) u_pend_enc (
    .bits_i (pend),
    .found_o(pend_found),
    .idx_o  (pend_idx)
  );

  irq_first_set #(.N(N), .IW(IW)) u_serv_enc (
    .bits_i (isr_q),
    .found_o(serv_found),
    .idx_o  (serv_idx)
  );

  assign int_o = pend_found && (!serv_found || (pend_idx < serv_idx));
  assign win_o = pend_idx;
  assign isr_o = isr_q;

  always_comb begin
    irr_d   = req_i;
    set_vec = (ack_i && int_o) ? (ONE << pend_idx) : '0;
    clr_vec = (eoi_i && serv_found) ? (ONE << serv_idx) : '0;
    isr_d   = (isr_q & ~clr_vec) | set_vec;
    isr_en  = ack_i | eoi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_d;
      if (isr_en) isr_q <= isr_d;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int LINES  = irq_nest_pkg::UNIT_LINES,
  parameter int BASE_W = irq_nest_pkg::BASE_W,
  parameter int LINK   = irq_nest_pkg::LINK_LINE,
  parameter int REDIR  = irq_nest_pkg::REDIR_IDX,
  localparam int IW    = $clog2(LINES),
  localparam int VW    = BASE_W + IW,
  localparam int TOT   = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOT-1:0]    irq_i,
  input  logic              cfg_we_i,
  input  logic [TOT-1:0]    cfg_mask_i,
  input  logic [BASE_W-1:0] cfg_base_pri_i,
  input  logic [BASE_W-1:0] cfg_base_sec_i,
  input  logic              ack_i,
  input  logic              eoi_pri_i,
  input  logic              eoi_sec_i,
  output logic              int_o,
  output logic              vec_vld_o,
  output logic [VW-1:0]     vec_o
);
  logic [TOT-1:0]    mask_q, mask_d;
  logic [BASE_W-1:0] bpri_q, bpri_d, bsec_q, bsec_d;
  logic [VW-1:0]     vec_q, vec_d;
  logic              vld_q;
  logic [LINES-1:0]  pri_req, sec_req, pri_isr, sec_isr;
  logic              pri_int, sec_int;
  logic [IW-1:0]     pri_win, sec_win;
  logic              pri_ack, sec_ack, link_win;

  for (genvar i = 0; i < LINES; i++) begin : g_req
    if (i == LINK) begin : g_link
      assign pri_req[i] = sec_int;
    end else begin : g_pri
      assign pri_req[i] = irq_i[i];
    end
    if (i == REDIR) begin : g_redir
      assign sec_req[i] = irq_i[LINES + i] | irq_i[LINK];
    end else begin : g_sec
      assign sec_req[i] = irq_i[LINES + i];
    end
  end

  assign link_win = (pri_win == LINK[IW-1:0]);
  assign pri_ack  = ack_i;
  assign sec_ack  = ack_i && pri_int && link_win;

  irq_nest_unit #(.N(LINES), .IW(IW)) u_pri (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (pri_req),
    .mask_i(mask_q[LINES-1:0]),
    .ack_i (pri_ack),
    .eoi_i (eoi_pri_i),
    .int_o (pri_int),
    .win_o (pri_win),
    .isr_o (pri_isr)
  );

  irq_nest_unit #(.N(LINES), .IW(IW)) u_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (sec_req),
    .mask_i(mask_q[TOT-1:LINES]),
    .ack_i (sec_ack),
    .eoi_i (eoi_sec_i),
    .int_o (sec_int),
    .win_o (sec_win),
    .isr_o (sec_isr)
  );

  always_comb begin
    mask_d = cfg_mask_i;
    bpri_d = cfg_base_pri_i;
    bsec_d = cfg_base_sec_i;
    if (!pri_int) begin
      vec_d = {bpri_q, {IW{1'b1}}};
    end else if (link_win) begin
      vec_d = sec_int ? {bsec_q, sec_win} : {bsec_q, {IW{1'b1}}};
    end else begin
      vec_d = {bpri_q, pri_win};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      bpri_q <= '0;
      bsec_q <= '0;
      vec_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        mask_q <= mask_d;
        bpri_q <= bpri_d;
        bsec_q <= bsec_d;
      end
      if (ack_i) vec_q <= vec_d;
      vld_q <= ack_i;
    end
  end

  assign int_o     = pri_int;
  assign vec_vld_o = vld_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int LINES = 8,
  parameter int VW    = 8,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             eoi_pri_i,
  input logic             eoi_sec_i,
  input logic             int_o,
  input logic             vec_vld_o,
  input logic [VW-1:0]    vec_o,
  input logic [LINES-1:0] pri_isr,
  input logic [LINES-1:0] sec_isr
);
  a_r11_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_vld_o);

  a_r11_vld_only_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_vld_o);

  a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi_pri_i && !eoi_sec_i) |=>
      (vec_o[IW-1:0] == {IW{1'b1}} && $stable(pri_isr) && $stable(sec_isr)));

  a_r6_ack_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !eoi_pri_i) |=>
      ($countones(pri_isr) == $countones($past(pri_isr)) + 1));

  a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pri_i && !ack_i && (|pri_isr)) |=>
      ($countones(pri_isr) + 1 == $countones($past(pri_isr))));

  a_r9_sec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pri_i && !eoi_sec_i && !ack_i) |=> $stable(sec_isr));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.LINES(LINES), .VW(VW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_i    (ack_i),
  .eoi_pri_i(eoi_pri_i),
  .eoi_sec_i(eoi_sec_i),
  .int_o    (int_o),
  .vec_vld_o(vec_vld_o),
  .vec_o    (vec_o),
  .pri_isr  (pri_isr),
  .sec_isr  (sec_isr)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [4:0] BP = 5'b01000;
  localparam logic [4:0] BS = 5'b01110;

  // {irq, mask, expected int, expected vector}
  localparam logic [40:0] TBL [NV] = '{
    {16'h0001, 16'h0000, 1'b1, 8'h40},
    {16'h0088, 16'h0000, 1'b1, 8'h43},
    {16'h0100, 16'h0000, 1'b1, 8'h70},
    {16'h0004, 16'h0000, 1'b1, 8'h71},
    {16'h8008, 16'h0000, 1'b1, 8'h77},
    {16'h8002, 16'h0000, 1'b1, 8'h41},
    {16'h0010, 16'h0010, 1'b0, 8'h00},
    {16'h0400, 16'h0004, 1'b0, 8'h00},
    {16'h0030, 16'h0010, 1'b1, 8'h45},
    {16'h0204, 16'h0000, 1'b1, 8'h71}
  };
  localparam string TAG [NV] = '{"R2", "R2", "R3", "R4", "R3", "R3", "R5", "R5", "R5", "R4"};

  logic clk, rst_n, cfg_we, ack, eoi_p, eoi_s;
  logic [15:0] irq, cfg_mask;
  logic int_o, vld;
  logic [7:0] vec;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we), .cfg_mask_i(cfg_mask),
    .cfg_base_pri_i(BP), .cfg_base_sec_i(BS), .ack_i(ack), .eoi_pri_i(eoi_p),
    .eoi_sec_i(eoi_s), .int_o(int_o), .vec_vld_o(vld), .vec_o(vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [15:0] m);
    cfg_mask = m; cfg_we = 1'b1;
    wait_n(1);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    ack = 1'b1;
    wait_n(1);
    ack = 1'b0;
    chk({tag, " vld"}, {15'd0, vld}, 16'd1);
    chk({tag, " vec"}, {8'd0, vec}, {8'd0, exp});
    wait_n(1);
    chk("R11 vld drops", {15'd0, vld}, 16'd0);
  endtask

  task automatic eoi(input logic p, input logic s);
    eoi_p = p; eoi_s = s;
    wait_n(1);
    eoi_p = 1'b0; eoi_s = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0; cfg_mask = '0;
    ack = 1'b0; eoi_p = 1'b0; eoi_s = 1'b0;
    wait_n(3);
    chk("R1 int in reset", {15'd0, int_o}, 16'd0);
    chk("R1 vld in reset", {15'd0, vld}, 16'd0);
    rst_n = 1'b1;
    irq = 16'hFFFF;
    wait_n(4);
    chk("R1 masked after reset", {15'd0, int_o}, 16'd0);
    irq = '0;

    for (int k = 0; k < NV; k++) begin
      cfg(TBL[k][24:9]);
      irq = TBL[k][40:25];
      wait_n(3);
      chk({TAG[k], " int"}, {15'd0, int_o}, {15'd0, TBL[k][8]});
      if (TBL[k][8]) do_ack(TAG[k], TBL[k][7:0]);
      irq = '0;
      eoi(1'b1, 1'b1);
      wait_n(3);
      chk({TAG[k], " idle"}, {15'd0, int_o}, 16'd0);
    end

    // R5: masked request stays pending, fires when unmasked
    cfg(16'h0010);
    irq = 16'h0010;
    wait_n(3);
    chk("R5 masked", {15'd0, int_o}, 16'd0);
    cfg(16'h0000);
    wait_n(1);
    chk("R5 unmasked", {15'd0, int_o}, 16'd1);
    do_ack("R5", 8'h44);
    irq = '0; eoi(1'b1, 1'b1); wait_n(3);

    // R10: spurious acknowledge
    do_ack("R10 spurious", 8'h47);
    irq = 16'h0080;
    wait_n(3);
    chk("R10 no isr set", {15'd0, int_o}, 16'd1);
    do_ack("R10", 8'h47);
    irq = '0; eoi(1'b1, 1'b1); wait_n(3);

    // R6/R7/R8 nesting on primary
    irq = 16'h0020;
    wait_n(3);
    do_ack("R6 line5", 8'h45);
    chk("R6 int drops", {15'd0, int_o}, 16'd0);
    irq = 16'h0060;
    wait_n(3);
    chk("R6 lower waits", {15'd0, int_o}, 16'd0);
    irq = 16'h0062;
    wait_n(3);
    chk("R7 preempt", {15'd0, int_o}, 16'd1);
    do_ack("R7 line1", 8'h41);
    irq = 16'h0060;
    eoi(1'b1, 1'b0);
    wait_n(3);
    chk("R8 one cleared", {15'd0, int_o}, 16'd0);
    eoi(1'b1, 1'b0);
    wait_n(1);
    chk("R8 second clear", {15'd0, int_o}, 16'd1);
    do_ack("R8 line5 again", 8'h45);
    irq = '0; eoi(1'b1, 1'b0); wait_n(3);

    // R9: cascaded source needs both strobes
    irq = 16'h0200;
    wait_n(3);
    do_ack("R9 line9", 8'h71);
    irq = 16'h0400;
    eoi(1'b1, 1'b0);
    wait_n(4);
    chk("R9 sec still busy", {15'd0, int_o}, 16'd0);
    eoi(1'b0, 1'b1);
    wait_n(3);
    chk("R9 released", {15'd0, int_o}, 16'd1);
    do_ack("R9 line10", 8'h72);
    irq = '0; eoi(1'b1, 1'b1); wait_n(3);
    chk("R9 idle", {15'd0, int_o}, 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule